// File: doc/BRIEF.md
# Hotplug Processor Register Window

This block is a small register window through which a host manages a set of hot-pluggable processors. It keeps, for every possible processor, an enabled flag, a pending-insert flag and a pending-remove flag. It also carries a 64-bit identifier for each processor, which arrives on an input. Every access beyond the selector register goes through an indirection: the host first stores the index of a processor in the selector, and then reads that processor's status, clears its event flags, or issues a command.

A command code chooses what the two data registers return. The codes are: the index of the processor found by a search for pending events, the low or high half of the identifier, or zero. The same command register also arms writes that load a status-report event word or a status-report status word. Loading the status word emits a one-cycle notification that carries both words.

The host bus is 32 bits wide and byte-addressed, with byte strobes. Accesses are word-aligned, and all multi-byte fields are little-endian. Read data is registered and appears one cycle after the read strobe, qualified by a valid flag.

Top module: `hp_reg_window`

## Requirements
- R1: After reset, processor 0 is enabled and has no events, every other processor is disabled with no events, the command register holds 0, and `note_valid` is low.
- R2: `bus_rdata` and `bus_rvalid` update on the clock edge that samples `bus_rd`, so read data is valid one cycle later. Byte strobe k carries the byte at offset base+k, which is little-endian lane order.
- R3: A write to the word at offset 0x0 stores the 32-bit selector, byte by byte under the strobes. The selector is valid only when its value is below N_PROCS.
- R4: While the selector is out of range, every read returns 0 and every write other than to the selector is dropped. A reset does not change the selector, and its power-up value is 0.
- R5: A read of the word at offset 0x4 returns the selected processor's status in byte 0: bit 0 is enabled, bit 1 is pending insert, bit 2 is pending remove. Bits 3 to 31 read as 0.
- R6: A write of byte 0 at offset 0x4 clears the insert flag when bit 1 is 1 and clears the remove flag when bit 2 is 1. Bit 0 and zero bits have no effect. An event that arrives in the same cycle takes priority over a clear.
- R7: Writing command code 0 to byte 1 of offset 0x4 (offset 0x5) moves the selector, in the same cycle, to the lowest-numbered processor that has either event flag set. The event flags are left unchanged.
- R8: When command 0 finds no processor with a pending event, the selector keeps its value.
- R9: The word at offset 0x8 reads the selector value after command 0, the low 32 bits of the selected identifier after command 3, and 0 after any other command.
- R10: The word at offset 0x0 reads the high 32 bits of the selected identifier after command 3, and 0 after any other command.
- R11: After command 1, a write to offset 0x8 loads the report event word under the strobes. After command 2, such a write loads the report status word, and `note_valid` is then high for exactly the one following cycle, with `note_event` and `note_status` showing both words.
- R12: Reserved locations read 0 and ignore writes. These are: offset 0x5 to 0x7 on read, bytes 2 and 3 of offset 0x4 on write, offset 0xC to 0xF, any address whose low two bits are not zero, and offset 0x8 writes under any command other than 1 or 2.
- R13: A one-cycle `ins_evt[i]` pulse sets processor i's enabled and insert flags. A `rem_evt[i]` pulse sets its remove flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (selector excluded) |
| bus_addr | input | 4 | Byte address within the window |
| bus_be | input | 4 | Byte strobes for writes |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| ins_evt | input | N_PROCS | Insert event pulses, one per processor |
| rem_evt | input | N_PROCS | Remove event pulses, one per processor |
| proc_uid | input | 64*N_PROCS | Identifier of processor i at bits [64i+63:64i] |
| note_valid | output | 1 | One-cycle pulse after a status-word load |
| note_event | output | 32 | Current report event word |
| note_status | output | 32 | Current report status word |

## Verification
An event pulse from the hot-add side and a host write that clears the same flag can land on one clock edge, and the flag must then remain set. The bench drives an insert pulse for the selected processor in the very cycle that a control-byte write clears its insert bit. It then judges the outcome by reading the status byte, which must still show bit 1. A second overlap is checked as well: the search reads the flags as registered before that edge. The bench raises events and issues the search in separate cycles, then confirms that the lowest pending index is chosen and that the flags are intact.

// File: rtl/hp_pkg.sv
package hp_pkg;

  typedef enum logic [1:0] {
    W_SEL  = 2'd0,
    W_CTL  = 2'd1,
    W_DAT  = 2'd2,
    W_NONE = 2'd3
  } word_e;

  localparam logic [7:0] CMD_SEARCH = 8'd0;
  localparam logic [7:0] CMD_RPT_EV = 8'd1;
  localparam logic [7:0] CMD_RPT_ST = 8'd2;
  localparam logic [7:0] CMD_UID    = 8'd3;

  function automatic logic [31:0] lane_merge(input logic [31:0] old_w,
                                             input logic [31:0] new_w,
                                             input logic [3:0]  be);
    logic [31:0] r;
    r = old_w;
    for (int k = 0; k < 4; k++)
      if (be[k]) r[8*k +: 8] = new_w[8*k +: 8];
    return r;
  endfunction

endpackage

// File: rtl/hp_event_search.sv
module hp_event_search #(
  parameter int N_PROCS = 8,
  localparam int IDX_W = (N_PROCS > 1) ? $clog2(N_PROCS) : 1
) (
  input  logic [N_PROCS-1:0] pend,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx
);

  // Scan downward so the lowest pending index is the last assignment.
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = N_PROCS - 1; i >= 0; i--) begin
      if (pend[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/hp_flag_bank.sv
module hp_flag_bank #(
  parameter int N_PROCS = 8,
  parameter logic [N_PROCS-1:0] BOOT_MASK = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_PROCS-1:0] set_ins,
  input  logic [N_PROCS-1:0] set_rem,
  input  logic [N_PROCS-1:0] clr_ins,
  input  logic [N_PROCS-1:0] clr_rem,
  output logic [N_PROCS-1:0] en_q,
  output logic [N_PROCS-1:0] ins_q,
  output logic [N_PROCS-1:0] rem_q
);

  for (genvar g = 0; g < N_PROCS; g++) begin : g_proc
    always_ff @(posedge clk) begin
      if (rst) begin
        en_q[g]  <= BOOT_MASK[g];
        ins_q[g] <= 1'b0;
        rem_q[g] <= 1'b0;
      end else begin
        if (set_ins[g]) en_q[g] <= 1'b1;
        // arrivals win over a simultaneous clear
        ins_q[g] <= set_ins[g] | (ins_q[g] & ~clr_ins[g]);
        rem_q[g] <= set_rem[g] | (rem_q[g] & ~clr_rem[g]);
      end
    end

    p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
      set_ins[g] |=> (ins_q[g] && en_q[g]));
    p_clear_ins_r6: assert property (@(posedge clk) disable iff (rst)
      (clr_ins[g] && !set_ins[g]) |=> !ins_q[g]);
    p_clear_rem_r6: assert property (@(posedge clk) disable iff (rst)
      (clr_rem[g] && !set_rem[g]) |=> !rem_q[g]);
  end

endmodule

// File: rtl/hp_report_regs.sv
module hp_report_regs (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_ev,
  input  logic        wr_st,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] ev_q,
  output logic [31:0] st_q,
  output logic        note_q
);
  import hp_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_q   <= '0;
      st_q   <= '0;
      note_q <= 1'b0;
    end else begin
      note_q <= wr_st;
      if (wr_ev) ev_q <= lane_merge(ev_q, wdata, be);
      if (wr_st) st_q <= lane_merge(st_q, wdata, be);
    end
  end

  p_note_cause_r11: assert property (@(posedge clk) disable iff (rst)
    note_q |-> $past(wr_st));
  p_note_follows_r11: assert property (@(posedge clk) disable iff (rst)
    wr_st |=> note_q);

endmodule

// File: rtl/hp_reg_window.sv
module hp_reg_window #(
  parameter int N_PROCS = 8,
  parameter logic [N_PROCS-1:0] BOOT_MASK = 1,
  localparam int IDX_W = (N_PROCS > 1) ? $clog2(N_PROCS) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [3:0]              bus_addr,
  input  logic [3:0]              bus_be,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  output logic                    bus_rvalid,
  input  logic [N_PROCS-1:0]      ins_evt,
  input  logic [N_PROCS-1:0]      rem_evt,
  input  logic [64*N_PROCS-1:0]   proc_uid,
  output logic                    note_valid,
  output logic [31:0]             note_event,
  output logic [31:0]             note_status
);
  import hp_pkg::*;

  // Selector has no reset: power-up value 0, preserved across rst.
  logic [31:0] sel_q = '0;
  logic [7:0]  cmd_q;

  word_e             word;
  logic              acc_ok, sel_ok;
  logic [IDX_W-1:0]  sel_idx;
  logic [N_PROCS-1:0] sel_1h;
  logic [63:0]       cur_uid;
  logic [N_PROCS-1:0] en_v, ins_v, rem_v, pend;
  logic [N_PROCS-1:0] clr_ins, clr_rem;
  logic              wr_sel, wr_ctl, wr_cmd, wr_dat, cmd_search;
  logic              srch_hit;
  logic [IDX_W-1:0]  srch_idx;
  logic [31:0]       rd_d;

  assign word    = word_e'(bus_addr[3:2]);
  assign acc_ok  = (bus_addr[1:0] == 2'b00);
  assign sel_ok  = (sel_q < 32'(N_PROCS));
  assign sel_idx = sel_ok ? sel_q[IDX_W-1:0] : '0;
  assign sel_1h  = sel_ok ? (N_PROCS'(1) << sel_idx) : '0;
  assign cur_uid = proc_uid[{sel_idx, 6'b0} +: 64];
  assign pend    = ins_v | rem_v;

  // write decode
  assign wr_sel     = bus_wr && acc_ok && (word == W_SEL);
  assign wr_ctl     = bus_wr && acc_ok && (word == W_CTL) && bus_be[0] && sel_ok;
  assign wr_cmd     = bus_wr && acc_ok && (word == W_CTL) && bus_be[1] && sel_ok;
  assign wr_dat     = bus_wr && acc_ok && (word == W_DAT) && sel_ok;
  assign cmd_search = wr_cmd && (bus_wdata[15:8] == CMD_SEARCH);
  assign clr_ins    = (wr_ctl && bus_wdata[1]) ? sel_1h : '0;
  assign clr_rem    = (wr_ctl && bus_wdata[2]) ? sel_1h : '0;

  hp_flag_bank #(.N_PROCS(N_PROCS), .BOOT_MASK(BOOT_MASK)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_ins (ins_evt),
    .set_rem (rem_evt),
    .clr_ins (clr_ins),
    .clr_rem (clr_rem),
    .en_q    (en_v),
    .ins_q   (ins_v),
    .rem_q   (rem_v)
  );

  hp_event_search #(.N_PROCS(N_PROCS)) u_search (
    .pend    (pend),
    .hit     (srch_hit),
    .hit_idx (srch_idx)
  );

  hp_report_regs u_report (
    .clk    (clk),
    .rst    (rst),
    .wr_ev  (wr_dat && (cmd_q == CMD_RPT_EV)),
    .wr_st  (wr_dat && (cmd_q == CMD_RPT_ST)),
    .be     (bus_be),
    .wdata  (bus_wdata),
    .ev_q   (note_event),
    .st_q   (note_status),
    .note_q (note_valid)
  );

  always_ff @(posedge clk) begin
    if (wr_sel)
      sel_q <= lane_merge(sel_q, bus_wdata, bus_be);
    else if (!rst && cmd_search && srch_hit)
      sel_q <= 32'(srch_idx);
  end

  always_ff @(posedge clk) begin
    if (rst)         cmd_q <= CMD_SEARCH;
    else if (wr_cmd) cmd_q <= bus_wdata[15:8];
  end

  // read mux
  always_comb begin
    rd_d = '0;
    if (acc_ok && sel_ok) begin
      case (word)
        W_SEL: if (cmd_q == CMD_UID) rd_d = cur_uid[63:32];
        W_CTL: rd_d = {29'd0, rem_v[sel_idx], ins_v[sel_idx], en_v[sel_idx]};
        W_DAT: begin
          if (cmd_q == CMD_SEARCH)   rd_d = sel_q;
          else if (cmd_q == CMD_UID) rd_d = cur_uid[31:0];
        end
        default: rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_d;
    end
  end

  p_rvalid_r2: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
  p_blank_read_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !sel_ok) |=> (bus_rdata == '0));
  p_drop_write_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !sel_ok && word != W_SEL) |=> $stable(cmd_q));
  p_status_rsvd_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && acc_ok && word == W_CTL) |=> (bus_rdata[31:3] == '0));
  p_search_pick_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_search && srch_hit) |=>
      ((($past(pend) >> sel_q[IDX_W-1:0]) & N_PROCS'(1)) != '0) &&
      (($past(pend) & ((N_PROCS'(1) << sel_q[IDX_W-1:0]) - N_PROCS'(1))) == '0));
  p_search_miss_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_search && !srch_hit) |=> $stable(sel_q));

endmodule

// File: tb/hp_reg_window_tb_top.sv
module hp_reg_window_tb_top;
  localparam int N = 6;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [3:0]      bus_addr = '0;
  logic [3:0]      bus_be = '0;
  logic            bus_wr = 1'b0;
  logic            bus_rd = 1'b0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic            bus_rvalid;
  logic [N-1:0]    ins_evt = '0;
  logic [N-1:0]    rem_evt = '0;
  logic [64*N-1:0] proc_uid;
  logic            note_valid;
  logic [31:0]     note_event, note_status;

  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  hp_reg_window #(.N_PROCS(N)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .ins_evt(ins_evt), .rem_evt(rem_evt), .proc_uid(proc_uid),
    .note_valid(note_valid), .note_event(note_event), .note_status(note_status)
  );

  function automatic logic [63:0] uid_of(input int i);
    return {32'hC0DE_0000 | 32'(i), 32'h0000_1000 + 32'(i)};
  endfunction

  initial for (int i = 0; i < N; i++) proc_uid[64*i +: 64] = uid_of(i);

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as read data appears
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) check(bus_rdata, 32'hDEAD_BEEF, "R2 unexpected read data");
      else check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse(input logic [N-1:0] ins, input logic [N-1:0] rem);
    @(negedge clk);
    ins_evt = ins; rem_evt = rem;
    @(negedge clk);
    ins_evt = '0; rem_evt = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic sel(input logic [31:0] v); wr(4'h0, 4'hF, v); endtask
  task automatic cmd(input logic [7:0] c);  wr(4'h4, 4'b0010, {16'd0, c, 8'd0}); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(4'h4, 32'h1, "R1 boot processor status");
    rd(4'h8, 32'h0, "R1 R9 command 0 data");
    rd(4'h0, 32'h0, "R1 R10 data2 after reset");
    check({31'd0, note_valid}, 32'h0, "R1 note idle");
    // R3 selector
    sel(32'd3);
    rd(4'h8, 32'd3, "R3 selector readback");
    rd(4'h4, 32'h0, "R5 idle processor status");
    // R13 events
    pulse(6'b001000, '0);
    rd(4'h4, 32'h3, "R13 insert sets en+ins");
    pulse('0, 6'b001000);
    rd(4'h4, 32'h7, "R13 remove flag");
    // R6 clears
    wr(4'h4, 4'b0001, 32'h1);
    rd(4'h4, 32'h7, "R6 bit0 reserved");
    wr(4'h4, 4'b0001, 32'h2);
    rd(4'h4, 32'h5, "R6 clear insert");
    wr(4'h4, 4'b0001, 32'h4);
    rd(4'h4, 32'h1, "R6 clear remove");
    // same-cycle arrival and clear
    @(negedge clk);
    bus_addr = 4'h4; bus_be = 4'b0001; bus_wdata = 32'h2; bus_wr = 1'b1; ins_evt = 6'b001000;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0; ins_evt = '0;
    rd(4'h4, 32'h3, "R6 R13 arrival beats clear");
    wr(4'h4, 4'b0001, 32'h2);
    rd(4'h4, 32'h1, "R6 insert cleared again");
    // R7 search
    pulse(6'b010000, 6'b000100);
    sel(32'd0);
    cmd(8'd0);
    rd(4'h8, 32'd2, "R7 lowest pending selected");
    rd(4'h4, 32'h4, "R7 flags kept at found");
    sel(32'd4);
    rd(4'h4, 32'h3, "R7 other flags kept");
    sel(32'd2); wr(4'h4, 4'b0001, 32'h4);
    sel(32'd4); wr(4'h4, 4'b0001, 32'h2);
    // R8 miss
    sel(32'd5);
    cmd(8'd0);
    rd(4'h8, 32'd5, "R8 miss keeps selector");
    // R9 R10 identifier
    sel(32'd4);
    cmd(8'd3);
    rd(4'h8, uid_of(4)[31:0], "R9 uid low");
    rd(4'h0, uid_of(4)[63:32], "R10 uid high");
    cmd(8'd7);
    rd(4'h8, 32'h0, "R9 other command");
    rd(4'h0, 32'h0, "R10 other command");
    rd(4'h4, 32'h1, "R12 R5 command byte reads 0");
    // R11 report
    cmd(8'd1); wr(4'h8, 4'hF, 32'h11);
    cmd(8'd2); wr(4'h8, 4'hF, 32'h22);
    check({31'd0, note_valid}, 32'h1, "R11 note pulse");
    check(note_event, 32'h11, "R11 note event");
    check(note_status, 32'h22, "R11 note status");
    @(negedge clk);
    check({31'd0, note_valid}, 32'h0, "R11 note one cycle");
    cmd(8'd1); wr(4'h8, 4'b0001, 32'hFFFF_FF33);
    cmd(8'd5); wr(4'h8, 4'hF, 32'h99);
    check({31'd0, note_valid}, 32'h0, "R12 reserved command no note");
    cmd(8'd2); wr(4'h8, 4'hF, 32'h55);
    check(note_event, 32'h33, "R11 R12 event byte lane merge");
    check(note_status, 32'h55, "R11 status second load");
    // R12 reserved
    rd(4'hC, 32'h0, "R12 beyond window");
    cmd(8'd3);
    wr(4'h4, 4'b1100, 32'hFFFF_0000);
    rd(4'h8, uid_of(4)[31:0], "R12 reserved lanes ignored");
    rd(4'h9, 32'h0, "R12 misaligned read");
    // R4 invalid selector
    pulse(6'b000010, '0);
    sel(32'd1); cmd(8'd0);
    sel(32'd6);
    rd(4'h4, 32'h0, "R4 status blanked");
    rd(4'h8, 32'h0, "R4 data blanked");
    wr(4'h4, 4'b0001, 32'h2);
    cmd(8'd3);
    sel(32'd1);
    rd(4'h4, 32'h3, "R4 clear dropped");
    rd(4'h8, 32'd1, "R4 command write dropped");
    wr(4'h0, 4'b1000, 32'h8000_0000);
    rd(4'h4, 32'h0, "R4 high byte invalid");
    wr(4'h0, 4'b1000, 32'h0);
    rd(4'h4, 32'h3, "R4 selector restored");
    // R2 lanes
    wr(4'h0, 4'b0001, 32'hAAAA_AA05);
    rd(4'h8, 32'd5, "R2 lane0 selector byte");
    // reset keeps selector
    sel(32'd4);
    do_reset();
    rd(4'h8, 32'd4, "R4 selector kept over reset");
    rd(4'h4, 32'h0, "R1 flags cleared by reset");
    repeat (3) @(negedge clk);
    check(32'(exp_q.size()), 32'd0, "R2 all reads returned");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule